// File: doc/BRIEF.md
# Prescaled Periodic Software Timer

This block is a free-running periodic timer that raises an interrupt-status flag at a programmable interval. It runs from a time-base clock. A fixed divide-by-256 prescaler turns that clock into period units, and a 16-bit period register sets how many units make up one interval. Once the interval elapses, the flag is set, the count starts again from zero, and the timer keeps repeating for as long as it stays enabled.

The timer stays idle until software first writes the period register. After that first write it counts without stopping. The flag holds until software clears it. There are two synchronous resets. A hard reset returns everything to its power-up state, and the period register then reads all ones. A soft reset restarts the count and drops the flag, but it keeps the period value and keeps the timer enabled. A stop input holds the count at zero and leaves the period value in place.

Top module: `sw_period_timer`

## Requirements
- R1: A write through `wr_en`/`wr_data` stores the 16-bit unsigned period value, and `rd_data` shows it from the clock edge that takes the write.
- R2: At a hard reset, `rd_data` becomes 16'hFFFF and `irq_flag` becomes 0. The timer is disarmed until the next period write.
- R3: Before the first period write after a hard reset, `irq_flag` never sets.
- R4: A write of period P≥1 on clock edge E0 sets `irq_flag` on edge E0+256·P and not before.
- R5: Without further writes, the flag is set again every 256·P edges. Clearing the flag between expiries does not shift this schedule.
- R6: `irq_clr` held high during one cycle clears `irq_flag` on that edge, when no expiry falls on the same edge.
- R7: When an expiry and `irq_clr` fall on the same edge, `irq_flag` ends up set.
- R8: A period write restarts both the prescaler and the period count. The next expiry comes 256·P_new edges after the write, and the old schedule is dropped.
- R9: A period value of 0 is illegal. While it is programmed, the count is held at zero and `irq_flag` never sets.
- R10: A soft reset clears `irq_flag` and restarts the count. It leaves the period value and the armed state as they were, so the next expiry comes 256·P edges after the last edge with `soft_rst` high.
- R11: While `stop` is high, the count is held at zero, no expiry occurs, and the period value is kept. The next expiry comes 256·P edges after the last edge with `stop` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| hard_rst | input | 1 | Synchronous active-high full reset |
| soft_rst | input | 1 | Synchronous active-high reset of count and flag only |
| stop | input | 1 | Holds the count at zero while high |
| wr_en | input | 1 | Period register write strobe |
| wr_data | input | 16 | Period value to write, in units of 256 clocks |
| rd_data | output | 16 | Current period register contents |
| irq_clr | input | 1 | Clears the interrupt-status flag |
| irq_flag | output | 1 | Interrupt-status flag, set at each expiry |

## Verification
All timing is counted from the edge that takes a write, a soft-reset cycle or the last stop cycle. `rd_data` changes on that same edge. `irq_flag` changes exactly 256·P edges later, and a clear takes effect on the edge that samples it. The bench drives every input on the falling edge and steps one falling edge per clock. It checks the flag one edge before each expected expiry, where it must still be low, and again at the expiry, where it must be high. To test R7, the clear is placed so that it lands on an expiry edge.

// File: rtl/swt_pkg.sv
package swt_pkg;

  // log2 of time-base clocks per period unit
  localparam int unsigned UNIT_LOG2 = 8;

  // shared control for prescaler and period counter
  typedef struct packed {
    logic restart;  // force count to zero
    logic run;      // advance when not restarting
  } swt_ctrl_t;

endpackage

// File: rtl/swt_prescaler.sv
module swt_prescaler
  import swt_pkg::*;
#(
  parameter int unsigned DIV_LOG2 = UNIT_LOG2
) (
  input  logic      clk,
  input  swt_ctrl_t ctrl,
  output logic      tick
);

  localparam logic [DIV_LOG2-1:0] LAST = {DIV_LOG2{1'b1}};

  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (ctrl.restart) begin
      div_q <= '0;
    end else if (ctrl.run) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick = ctrl.run && !ctrl.restart && (div_q == LAST);

endmodule

// File: rtl/swt_period_counter.sv
module swt_period_counter
  import swt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  swt_ctrl_t        ctrl,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic             expire
);

  logic [CNT_W-1:0] units_q;
  logic             at_end;

  assign at_end = (units_q == period - 1'b1);
  assign expire = tick && at_end;

  always_ff @(posedge clk) begin
    if (ctrl.restart) begin
      units_q <= '0;
    end else if (tick) begin
      if (at_end) begin
        units_q <= '0;
      end else begin
        units_q <= units_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swt_irq_flag.sv
module swt_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;   // expiry wins over a same-cycle clear
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/sw_period_timer.sv
module sw_period_timer
  import swt_pkg::*;
#(
  parameter int unsigned PERIOD_W  = 16,
  parameter int unsigned DIV_LOG2  = UNIT_LOG2
) (
  input  logic                clk,
  input  logic                hard_rst,
  input  logic                soft_rst,
  input  logic                stop,
  input  logic                wr_en,
  input  logic [PERIOD_W-1:0] wr_data,
  output logic [PERIOD_W-1:0] rd_data,
  input  logic                irq_clr,
  output logic                irq_flag
);

  localparam logic [PERIOD_W-1:0] PERIOD_INIT = {PERIOD_W{1'b1}};

  logic [PERIOD_W-1:0] period_q;
  logic                armed_q;
  logic                zero_period;
  logic                tick_w;
  logic                expire_w;
  swt_ctrl_t           ctrl;

  // period register and first-write arming
  always_ff @(posedge clk) begin
    if (hard_rst) begin
      period_q <= PERIOD_INIT;
      armed_q  <= 1'b0;
    end else if (wr_en) begin
      period_q <= wr_data;
      armed_q  <= 1'b1;
    end
  end

  assign zero_period = (period_q == '0);

  always_comb begin
    ctrl.restart = hard_rst || soft_rst || stop || wr_en || !armed_q || zero_period;
    ctrl.run     = armed_q && !zero_period;
  end

  swt_prescaler #(
    .DIV_LOG2 (DIV_LOG2)
  ) u_div (
    .clk  (clk),
    .ctrl (ctrl),
    .tick (tick_w)
  );

  swt_period_counter #(
    .CNT_W (PERIOD_W)
  ) u_cnt (
    .clk    (clk),
    .ctrl   (ctrl),
    .tick   (tick_w),
    .period (period_q),
    .expire (expire_w)
  );

  swt_irq_flag u_flag (
    .clk  (clk),
    .rst  (hard_rst || soft_rst),
    .set  (expire_w),
    .clr  (irq_clr),
    .flag (irq_flag)
  );

  assign rd_data = period_q;

endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
  parameter int unsigned PERIOD_W = 16
) (
  input logic                clk,
  input logic                hard_rst,
  input logic                soft_rst,
  input logic                wr_en,
  input logic                irq_clr,
  input logic                irq_flag,
  input logic [PERIOD_W-1:0] rd_data,
  input logic                expire,
  input logic                armed
);

  // R2
  hard_reset_value_chk: assert property (@(posedge clk) disable iff (hard_rst)
    $fell(hard_rst) |-> (rd_data == {PERIOD_W{1'b1}}) && !irq_flag);

  // R3
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (hard_rst)
    !armed |-> !expire);

  // R4
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (!irq_flag && !soft_rst && !expire) |=> !irq_flag);

  // R6
  clear_effect_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (irq_clr && !expire) |=> !irq_flag);

  // R7
  expiry_wins_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (expire && !soft_rst) |=> irq_flag);

  // R9
  zero_period_quiet_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (rd_data == '0) |-> !expire);

  // R10
  soft_keeps_period_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (soft_rst && !wr_en) |=> (rd_data == $past(rd_data)) && !irq_flag);

endmodule

bind sw_period_timer swt_checker #(
  .PERIOD_W (PERIOD_W)
) u_chk (
  .clk      (clk),
  .hard_rst (hard_rst),
  .soft_rst (soft_rst),
  .wr_en    (wr_en),
  .irq_clr  (irq_clr),
  .irq_flag (irq_flag),
  .rd_data  (rd_data),
  .expire   (expire_w),
  .armed    (armed_q)
);

// File: tb/sw_period_timer_bench.sv
module sw_period_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int UNIT = 256;
  localparam int WATCHDOG = 60000;

  logic        clk = 1'b0;
  logic        hard_rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        stop = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_clr = 1'b0;
  logic        irq_flag;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_period_timer u_sw_period_timer (
    .clk      (clk),
    .hard_rst (hard_rst),
    .soft_rst (soft_rst),
    .stop     (stop),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq_clr  (irq_clr),
    .irq_flag (irq_flag)
  );

  task automatic chk_bit(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s irq_flag actual=%0b expected=%0b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_word(input logic [15:0] act, input logic [15:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s rd_data actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  // advance n clock edges; caller sits just after a falling edge
  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_period(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset_state();
    hard_rst = 1'b1;
    adv(3);
    hard_rst = 1'b0;
    adv(1);
    chk_word(rd_data, 16'hFFFF, "R2");
    chk_bit(irq_flag, 1'b0, "R2");
  endtask

  task automatic t_unarmed();
    adv(700);
    chk_bit(irq_flag, 1'b0, "R3");
  endtask

  task automatic t_period_two();
    write_period(16'd2);
    chk_word(rd_data, 16'd2, "R1");
    adv(2*UNIT - 1);
    chk_bit(irq_flag, 1'b0, "R4 early");
    adv(1);
    chk_bit(irq_flag, 1'b1, "R4 on time");
    pulse_clr();                      // edge 513
    chk_bit(irq_flag, 1'b0, "R6");
    adv(4*UNIT - 1 - (2*UNIT + 1));   // edge 1023
    chk_bit(irq_flag, 1'b0, "R5 early");
    adv(1);                           // edge 1024
    chk_bit(irq_flag, 1'b1, "R5 repeat");
  endtask

  task automatic t_clear_collision();
    pulse_clr();                      // edge 1025
    chk_bit(irq_flag, 1'b0, "R6");
    adv(6*UNIT - 1 - (4*UNIT + 1));   // edge 1535
    chk_bit(irq_flag, 1'b0, "R5 early");
    pulse_clr();                      // clear lands on expiry edge 1536
    chk_bit(irq_flag, 1'b1, "R7");
  endtask

  task automatic t_reload();
    pulse_clr();
    write_period(16'd3);
    chk_word(rd_data, 16'd3, "R1");
    adv(3*UNIT - 1);
    chk_bit(irq_flag, 1'b0, "R8 old schedule dropped");
    adv(1);
    chk_bit(irq_flag, 1'b1, "R8 new period");
  endtask

  task automatic t_zero();
    write_period(16'd0);
    pulse_clr();
    adv(1200);
    chk_word(rd_data, 16'd0, "R9");
    chk_bit(irq_flag, 1'b0, "R9");
  endtask

  task automatic t_soft();
    write_period(16'd1);
    adv(UNIT);
    chk_bit(irq_flag, 1'b1, "R4 period one");
    adv(50);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk_bit(irq_flag, 1'b0, "R10 flag cleared");
    chk_word(rd_data, 16'd1, "R10 period kept");
    adv(UNIT - 1);
    chk_bit(irq_flag, 1'b0, "R10 early");
    adv(1);
    chk_bit(irq_flag, 1'b1, "R10 resumes");
  endtask

  task automatic t_stop();
    pulse_clr();
    stop = 1'b1;
    adv(600);
    stop = 1'b0;
    chk_bit(irq_flag, 1'b0, "R11 held");
    chk_word(rd_data, 16'd1, "R11 period kept");
    adv(UNIT - 1);
    chk_bit(irq_flag, 1'b0, "R11 early");
    adv(1);
    chk_bit(irq_flag, 1'b1, "R11 resumes");
  endtask

  task automatic t_hard_again();
    hard_rst = 1'b1;
    adv(1);
    hard_rst = 1'b0;
    chk_word(rd_data, 16'hFFFF, "R2 rearm value");
    chk_bit(irq_flag, 1'b0, "R2 flag");
    adv(600);
    chk_bit(irq_flag, 1'b0, "R3 disarmed");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_unarmed();
    t_period_two();
    t_clear_collision();
    t_reload();
    t_zero();
    t_soft();
    t_stop();
    t_hard_again();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule